// File: doc/BRIEF.md
# Power Domain Power-Up and Power-Down Sequencer

This block sits on the requesting side of a gated power domain. It turns a single enable or disable command into the ordered set of control actions that the domain needs. These actions are pulses on the domain reset and on an always-on reset, release or assertion of the IO clamp, the collapse and hardware-trigger controls toward the domain controller, and the memory/peripheral retention request. Between steps it waits fixed settle times. Where the domain must confirm a change, it polls the domain's power status with a bounded wait.

A set of static configuration inputs chooses which optional steps run:
- a software reset pulse;
- clamp handling, with an optional always-on reset pulse;
- retention for domains that can be switched fully off;
- hardware-trigger hand-off;
- an extra settle time for domains behind a hardware vote controller;
- fixed-wait power-down for shared (votable) domains;
- an always-on mode in which only the reset moves.

All delays are cycle counts derived from a clock-frequency parameter. A completed sequence gives a one-cycle `done_o`. A status poll that runs out of time aborts the sequence with a one-cycle `timeout_o`.

Top module: `pdom_seq`

## Requirements
- R1: After reset: `collapse_o`=1, `clamp_o`=1, and `dom_rst_o`, `aon_rst_o`, `retain_o`, `hwtrig_o`, `done_o`, `timeout_o` all 0.
- R2: On enable with `cfg_sw_rst`=1, `dom_rst_o` is high for exactly US_CYC cycles (US_CYC = CLK_MHZ × SETTLE_US). It falls no later than the cycle in which `collapse_o` falls.
- R3: On enable with `cfg_clamp`=1, `clamp_o` falls strictly before `collapse_o` falls. If `cfg_aon_rst`=1 as well, `aon_rst_o` is high for exactly US_CYC cycles and falls no later than `clamp_o` falls.
- R4: If power-on status is never seen, `timeout_o` pulses between TO_CYC and TO_CYC+US_CYC+8 cycles after `collapse_o` falls (TO_CYC = CLK_MHZ × POLL_US). The check at the deadline is included. The sequence is then abandoned: no `done_o`, and retention is not set.
- R5: Once power-on is confirmed, `retain_o` rises when `cfg_off_cap`=1 and stays low otherwise. `hwtrig_o`, when `cfg_hw_trig`=1, rises at least US_CYC cycles after `retain_o`. `done_o` then pulses once.
- R6: With `cfg_hw_vote`=1, `stat_on` is not accepted before US_CYC cycles have passed since `collapse_o` fell. `retain_o` rises at least US_CYC+1 cycles after that fall.
- R7: On disable, the steps run in this order:
  - `hwtrig_o` falls first;
  - at least US_CYC cycles later, after an on-status check, `retain_o` falls;
  - `collapse_o` rises strictly after that;
  - `clamp_o` rises strictly after that, when `cfg_clamp`=1;
  - `done_o` pulses.
- R8: On disable with `cfg_votable`=1, status is not polled. `done_o` pulses TO_CYC to TO_CYC+2 cycles after `collapse_o` rises, even while `stat_on` stays 1.
- R9: With `cfg_on_only`=1:
  - disable only raises `dom_rst_o`, and enable only lowers it;
  - `collapse_o` and `clamp_o` do not change;
  - `done_o` pulses within 3 cycles.
- R10: Commands arriving while a sequence runs are ignored and do not change its outcome. If both commands arrive in the same idle cycle, enable wins.
- R11: `done_o` and `timeout_o` are each one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_cmd | input | 1 | Start power-up sequence (sampled when idle) |
| dis_cmd | input | 1 | Start power-down sequence (sampled when idle) |
| cfg_on_only | input | 1 | Domain supports only the on state |
| cfg_sw_rst | input | 1 | Pulse domain reset on power-up |
| cfg_clamp | input | 1 | Domain has an IO clamp to handle |
| cfg_aon_rst | input | 1 | Pulse always-on reset before clamp release |
| cfg_off_cap | input | 1 | Domain can be fully off; drive retention |
| cfg_hw_trig | input | 1 | Hand over to hardware trigger mode |
| cfg_hw_vote | input | 1 | Domain behind a vote controller; settle before polling |
| cfg_votable | input | 1 | Shared domain; power-down uses a fixed wait |
| stat_on | input | 1 | Domain power status, 1 = on (asynchronous) |
| collapse_o | output | 1 | Collapse request to the domain controller |
| hwtrig_o | output | 1 | Hardware trigger mode enable |
| dom_rst_o | output | 1 | Domain reset |
| aon_rst_o | output | 1 | Always-on logic reset |
| clamp_o | output | 1 | IO clamp |
| retain_o | output | 1 | Memory and peripheral retention |
| done_o | output | 1 | One-cycle sequence-complete pulse |
| timeout_o | output | 1 | One-cycle status-poll timeout pulse |

## Verification
A corrupted sequencer state shows up at the ports as a control edge out of order or a pulse of the wrong width. Examples are collapse released while the clamp still holds, or reset high longer than one settle time. The bench timestamps every edge and compares gaps and widths in cycles, so such a fault is visible within one settle period of the faulty step. A stuck poll or lost timer shows up as a missing `done_o` or `timeout_o` within one poll window. A skipped wait shows up as a retention edge arriving too early after collapse falls.

// File: rtl/pdom_seq_pkg.sv
package pdom_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_EN_RST,
        S_EN_AON,
        S_EN_UNCLAMP,
        S_EN_PWR,
        S_EN_POLL,
        S_EN_SETTLE,
        S_EN_HWT,
        S_DIS_HWT,
        S_DIS_POLL_ON,
        S_DIS_COLL,
        S_DIS_WAIT,
        S_DIS_POLL_OFF
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       coll;
        logic       hwt;
        logic       rst;
        logic       aon;
        logic       clamp;
        logic       ret;
        logic       done;
        logic       tout;
    } seq_regs_t;

endpackage

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // Counter never rises except through a load
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q))); // R4
endmodule

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pdom_seq.sv
module pdom_seq
    import pdom_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 10,
    parameter int SETTLE_US   = 1,
    parameter int POLL_US     = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic cfg_on_only,
    input  logic cfg_sw_rst,
    input  logic cfg_clamp,
    input  logic cfg_aon_rst,
    input  logic cfg_off_cap,
    input  logic cfg_hw_trig,
    input  logic cfg_hw_vote,
    input  logic cfg_votable,
    input  logic stat_on,
    output logic collapse_o,
    output logic hwtrig_o,
    output logic dom_rst_o,
    output logic aon_rst_o,
    output logic clamp_o,
    output logic retain_o,
    output logic done_o,
    output logic timeout_o
);
    localparam int US_CYC = CLK_MHZ * SETTLE_US;
    localparam int TO_CYC = CLK_MHZ * POLL_US;
    localparam int CW     = $clog2(TO_CYC + 1);
    localparam logic [CW-1:0] US_M1 = CW'(US_CYC - 1);
    localparam logic [CW-1:0] TO_M1 = CW'(TO_CYC - 1);

    seq_regs_t     q, n;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic          st_sync;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(stat_on), .dout(st_sync)
    );

    pdseq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.tout   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            S_IDLE: begin
                if (en_cmd) begin
                    if (cfg_on_only) begin
                        n.rst  = 1'b0;
                        n.done = 1'b1;
                    end else begin
                        n.rst    = cfg_sw_rst;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_sw_rst ? US_M1 : '0;
                        n.st     = S_EN_RST;
                    end
                end else if (dis_cmd) begin
                    if (cfg_on_only) begin
                        n.rst  = 1'b1;
                        n.done = 1'b1;
                    end else if (cfg_hw_trig) begin
                        n.hwt    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = US_M1;
                        n.st     = S_DIS_HWT;
                    end else begin
                        if (cfg_off_cap) n.ret = 1'b0;
                        n.st = S_DIS_COLL;
                    end
                end
            end
            S_EN_RST: begin
                if (tmr_exp) begin
                    n.rst    = 1'b0;
                    n.aon    = cfg_clamp & cfg_aon_rst;
                    tmr_load = 1'b1;
                    tmr_val  = (cfg_clamp & cfg_aon_rst) ? US_M1 : '0;
                    n.st     = S_EN_AON;
                end
            end
            S_EN_AON: begin
                if (tmr_exp) begin
                    n.aon = 1'b0;
                    if (cfg_clamp) n.clamp = 1'b0;
                    n.st = S_EN_UNCLAMP;
                end
            end
            S_EN_UNCLAMP: begin
                n.coll   = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = cfg_hw_vote ? US_M1 : '0;
                n.st     = S_EN_PWR;
            end
            S_EN_PWR: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TO_M1;
                    n.st     = S_EN_POLL;
                end
            end
            S_EN_POLL: begin
                if (st_sync) begin
                    if (cfg_off_cap) n.ret = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = US_M1;
                    n.st     = S_EN_SETTLE;
                end else if (tmr_exp) begin
                    n.tout = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_EN_SETTLE: begin
                if (tmr_exp) begin
                    if (cfg_hw_trig) begin
                        n.hwt    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = US_M1;
                        n.st     = S_EN_HWT;
                    end else begin
                        n.done = 1'b1;
                        n.st   = S_IDLE;
                    end
                end
            end
            S_EN_HWT: begin
                if (tmr_exp) begin
                    n.done = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_DIS_HWT: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TO_M1;
                    n.st     = S_DIS_POLL_ON;
                end
            end
            S_DIS_POLL_ON: begin
                if (st_sync) begin
                    if (cfg_off_cap) n.ret = 1'b0;
                    n.st = S_DIS_COLL;
                end else if (tmr_exp) begin
                    n.tout = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_DIS_COLL: begin
                n.coll   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = cfg_votable ? TO_M1 : (cfg_hw_vote ? US_M1 : '0);
                n.st     = S_DIS_WAIT;
            end
            S_DIS_WAIT: begin
                if (tmr_exp) begin
                    if (cfg_votable) begin
                        if (cfg_clamp) n.clamp = 1'b1;
                        n.done = 1'b1;
                        n.st   = S_IDLE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TO_M1;
                        n.st     = S_DIS_POLL_OFF;
                    end
                end
            end
            S_DIS_POLL_OFF: begin
                if (!st_sync) begin
                    if (cfg_clamp) n.clamp = 1'b1;
                    n.done = 1'b1;
                    n.st   = S_IDLE;
                end else if (tmr_exp) begin
                    n.tout = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.coll  <= 1'b1;
            q.clamp <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign collapse_o = q.coll;
    assign hwtrig_o   = q.hwt;
    assign dom_rst_o  = q.rst;
    assign aon_rst_o  = q.aon;
    assign clamp_o    = q.clamp;
    assign retain_o   = q.ret;
    assign done_o     = q.done;
    assign timeout_o  = q.tout;

    // Width watch for the always-on reset pulse
    logic [CW-1:0] aon_cnt_d, aon_cnt_q;
    always_comb aon_cnt_d = aon_rst_o ? aon_cnt_q + 1'b1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aon_cnt_q <= '0;
        else        aon_cnt_q <= aon_cnt_d;
    end

    AST_AON_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        aon_rst_o |-> (aon_cnt_q < CW'(US_CYC))); // R3
    AST_CLAMP_FREED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(collapse_o) && cfg_clamp) |-> !clamp_o); // R3
    AST_RET_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retain_o) |-> !collapse_o); // R5
    AST_HWT_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        hwtrig_o |-> !collapse_o); // R5
    AST_CLAMP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_o) |-> collapse_o); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_TOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R11
    AST_NO_DONE_AND_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R11
endmodule

// File: tb/tb_pdom_seq.sv
module tb_pdom_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ = 10;
    localparam int US = CLK_MHZ * 1;
    localparam int TO = CLK_MHZ * 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_cmd = 0, dis_cmd = 0;
    logic cfg_on_only = 0, cfg_sw_rst = 0, cfg_clamp = 0, cfg_aon_rst = 0;
    logic cfg_off_cap = 0, cfg_hw_trig = 0, cfg_hw_vote = 0, cfg_votable = 0;
    logic stat_on;
    logic collapse_o, hwtrig_o, dom_rst_o, aon_rst_o, clamp_o, retain_o, done_o, timeout_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdom_seq #(.CLK_MHZ(CLK_MHZ)) dut (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .cfg_on_only(cfg_on_only), .cfg_sw_rst(cfg_sw_rst), .cfg_clamp(cfg_clamp),
        .cfg_aon_rst(cfg_aon_rst), .cfg_off_cap(cfg_off_cap), .cfg_hw_trig(cfg_hw_trig),
        .cfg_hw_vote(cfg_hw_vote), .cfg_votable(cfg_votable), .stat_on(stat_on),
        .collapse_o(collapse_o), .hwtrig_o(hwtrig_o), .dom_rst_o(dom_rst_o),
        .aon_rst_o(aon_rst_o), .clamp_o(clamp_o), .retain_o(retain_o),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    // Domain model: status follows collapse after three cycles unless forced
    logic [2:0] dom_sh = 3'b000;
    int force_mode = 0; // 0 follow, 1 stuck off, 2 stuck on
    always @(posedge clk) dom_sh <= {dom_sh[1:0], ~collapse_o};
    assign stat_on = (force_mode == 1) ? 1'b0 : (force_mode == 2) ? 1'b1 : dom_sh[2];

    int checks = 0, failures = 0;
    int cyc = 0;
    int t_rst_r, t_rst_f, t_aon_r, t_aon_f, t_clamp_f, t_clamp_r;
    int t_coll_f, t_coll_r, t_ret_r, t_ret_f, t_hw_r, t_hw_f, t_done, t_to;
    int n_done = 0, n_to = 0;
    logic p_rst = 0, p_aon = 0, p_clamp = 1, p_coll = 1, p_ret = 0, p_hw = 0;

    always @(negedge clk) begin
        cyc++;
        if (dom_rst_o && !p_rst) t_rst_r = cyc;
        if (!dom_rst_o && p_rst) t_rst_f = cyc;
        if (aon_rst_o && !p_aon) t_aon_r = cyc;
        if (!aon_rst_o && p_aon) t_aon_f = cyc;
        if (clamp_o && !p_clamp) t_clamp_r = cyc;
        if (!clamp_o && p_clamp) t_clamp_f = cyc;
        if (collapse_o && !p_coll) t_coll_r = cyc;
        if (!collapse_o && p_coll) t_coll_f = cyc;
        if (retain_o && !p_ret) t_ret_r = cyc;
        if (!retain_o && p_ret) t_ret_f = cyc;
        if (hwtrig_o && !p_hw) t_hw_r = cyc;
        if (!hwtrig_o && p_hw) t_hw_f = cyc;
        if (done_o) begin n_done++; t_done = cyc; end
        if (timeout_o) begin n_to++; t_to = cyc; end
        p_rst = dom_rst_o; p_aon = aon_rst_o; p_clamp = clamp_o;
        p_coll = collapse_o; p_ret = retain_o; p_hw = hwtrig_o;
    end

    task automatic clear_stamps();
        t_rst_r = -1; t_rst_f = -1; t_aon_r = -1; t_aon_f = -1;
        t_clamp_f = -1; t_clamp_r = -1; t_coll_f = -1; t_coll_r = -1;
        t_ret_r = -1; t_ret_f = -1; t_hw_r = -1; t_hw_f = -1;
        t_done = -1; t_to = -1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse_cmd(input bit en);
        @(negedge clk);
        if (en) en_cmd = 1; else dis_cmd = 1;
        @(negedge clk);
        en_cmd = 0; dis_cmd = 0;
    endtask

    task automatic wait_end(input int limit);
        int base = n_done + n_to;
        for (int i = 0; i < limit; i++) begin
            if (n_done + n_to != base) break;
            step();
        end
        repeat (3) step();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
    endtask

    task automatic set_cfg(input bit on_only, sw, cl, aon, off, hwt, hwv, vot);
        cfg_on_only = on_only; cfg_sw_rst = sw; cfg_clamp = cl; cfg_aon_rst = aon;
        cfg_off_cap = off; cfg_hw_trig = hwt; cfg_hw_vote = hwv; cfg_votable = vot;
    endtask

    task automatic t_reset_state();
        chk(collapse_o == 1 && clamp_o == 1, "R1 collapse/clamp", {collapse_o, clamp_o}, 3);
        chk({dom_rst_o, aon_rst_o, retain_o, hwtrig_o, done_o, timeout_o} == 0,
            "R1 other outputs", {dom_rst_o, aon_rst_o, retain_o, hwtrig_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_enable_full();
        int d0 = n_done;
        set_cfg(0, 1, 1, 1, 1, 1, 0, 0);
        force_mode = 0;
        clear_stamps();
        pulse_cmd(1);
        repeat (3) step();
        pulse_cmd(0); // R10: ignored while busy
        wait_end(20000);
        chk(t_rst_f - t_rst_r == US, "R2 reset width", t_rst_f - t_rst_r, US);
        chk(t_rst_f <= t_coll_f, "R2 reset before power", t_rst_f, t_coll_f);
        chk(t_aon_f - t_aon_r == US, "R3 aon width", t_aon_f - t_aon_r, US);
        chk(t_aon_f <= t_clamp_f && t_clamp_f < t_coll_f, "R3 clamp order", t_clamp_f, t_coll_f);
        chk(t_ret_r > t_coll_f, "R5 retain after power", t_ret_r, t_coll_f);
        chk(t_hw_r - t_ret_r >= US, "R5 hwtrig settle", t_hw_r - t_ret_r, US);
        chk(n_done - d0 == 1, "R5 done once", n_done - d0, 1);
        chk(collapse_o == 0 && retain_o == 1 && hwtrig_o == 1, "R10 outcome kept",
            {collapse_o, retain_o, hwtrig_o}, 3);
    endtask

    task automatic t_disable_full();
        int d0 = n_done;
        clear_stamps();
        pulse_cmd(0);
        wait_end(20000);
        chk(t_hw_f >= 0 && t_ret_f - t_hw_f >= US, "R7 hwtrig first then settle", t_ret_f - t_hw_f, US);
        chk(t_ret_f < t_coll_r, "R7 retain before collapse", t_ret_f, t_coll_r);
        chk(t_coll_r < t_clamp_r, "R7 clamp last", t_clamp_r, t_coll_r);
        chk(n_done - d0 == 1, "R7 done", n_done - d0, 1);
    endtask

    task automatic t_vote_paths();
        int d0;
        set_cfg(0, 0, 0, 0, 1, 0, 1, 0);
        force_mode = 0;
        clear_stamps();
        pulse_cmd(1);
        wait_end(20000);
        chk(t_ret_r - t_coll_f >= US + 1, "R6 vote settle before poll", t_ret_r - t_coll_f, US + 1);
        chk(clamp_o == 1, "R3 clamp untouched without option", clamp_o, 1);
        cfg_votable = 1;
        force_mode = 2;
        d0 = n_done;
        clear_stamps();
        pulse_cmd(0);
        wait_end(20000);
        chk(n_done - d0 == 1, "R8 votable done", n_done - d0, 1);
        chk(t_done - t_coll_r >= TO && t_done - t_coll_r <= TO + 2, "R8 fixed wait",
            t_done - t_coll_r, TO);
        force_mode = 0;
        repeat (6) step();
    endtask

    task automatic t_timeout();
        int d0 = n_done, o0 = n_to;
        set_cfg(0, 0, 0, 0, 1, 0, 0, 0);
        force_mode = 1;
        clear_stamps();
        pulse_cmd(1);
        wait_end(20000);
        chk(n_to - o0 == 1 && n_done == d0, "R4 timeout not done", n_to - o0, 1);
        chk(t_to - t_coll_f >= TO && t_to - t_coll_f <= TO + US + 8, "R4 window",
            t_to - t_coll_f, TO);
        chk(retain_o == 0, "R4 abandoned", retain_o, 0);
        force_mode = 0;
        do_reset();
    endtask

    task automatic t_on_only();
        int d0 = n_done;
        set_cfg(1, 0, 1, 0, 1, 0, 0, 0);
        clear_stamps();
        pulse_cmd(0);
        step();
        chk(dom_rst_o == 1 && collapse_o == 1 && clamp_o == 1, "R9 disable only reset",
            {dom_rst_o, collapse_o, clamp_o}, 7);
        chk(n_done - d0 == 1 && t_done > 0, "R9 done", n_done - d0, 1);
        pulse_cmd(1);
        step();
        chk(dom_rst_o == 0 && collapse_o == 1 && clamp_o == 1, "R9 enable only reset",
            {dom_rst_o, collapse_o, clamp_o}, 3);
        chk(n_done - d0 == 2, "R11 one pulse each", n_done - d0, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=finished", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_stamps();
        do_reset();
        t_reset_state();
        t_enable_full();
        t_disable_full();
        t_vote_paths();
        t_timeout();
        t_on_only();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule